// File: doc/BRIEF.md
# Privilege-Gated Counter Read Port

This block sits beside a processor's control-register file and answers reads of the performance counter registers. It holds a free-running cycle count and a retired-instruction count, and takes a time value from outside. Every access is checked against the current privilege level and two 32-bit enable masks. One mask is set from machine mode and governs supervisor reads. The other is set from supervisor mode and governs user reads.

A permitted read returns the selected count. A refused read returns zero and raises a denial flag, which the surrounding core can turn into an illegal-instruction trap. All performance-monitor slots from 3 to 31 mirror the cycle count. Each counter also has an upper-half alias that returns bits 63 to 32 of its 64-bit count. These aliases let a 32-bit core read the full value. The read path is purely combinational. Only the two counts are registered.

Top module: `ctr_read_gate`

## Requirements
- R1: `rd_hit_o` is 1 exactly when `csr_addr_i` is 0xC00+n (lower half) or 0xC80+n (upper half) for n in 0..31. Any other address gives `rd_hit_o`=0, `rd_denied_o`=0 and `rd_data_o`=0.
- R2: With `priv_i`=2'b11 (machine), no counter read is denied.
- R3: With `priv_i`=2'b01 (supervisor), counter n is readable only when `mcen_i[n]` is 1.
- R4: With `priv_i`=2'b00 (user), counter n is readable only when `scen_i[n]` is 1.
- R5: With `priv_i`=2'b10 (reserved), every counter read is denied.
- R6: A denied read drives `rd_data_o` to zero and `rd_denied_o` to 1 in the same cycle.
- R7: Counter n=0 returns the cycle count. The count is 0 while `rst_n` is low and grows by one on every rising clock edge after reset is released.
- R8: Counter n=1 returns `time_i`.
- R9: Counter n=2 returns the retire count. The count is 0 in reset and grows by one on each rising edge where `retire_i` is 1.
- R10: Counters n=3..31 return the cycle count.
- R11: A lower-half address returns count bits [XLEN-1:0]. An upper-half address returns count bits [63:32], zero-extended to XLEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the counts |
| retire_i | input | 1 | One instruction retired this cycle |
| time_i | input | 64 | Current time value |
| priv_i | input | 2 | Privilege: 00 user, 01 supervisor, 11 machine |
| mcen_i | input | 32 | Machine-set enable mask for supervisor reads |
| scen_i | input | 32 | Supervisor-set enable mask for user reads |
| csr_addr_i | input | 12 | Register address being read |
| rd_data_o | output | XLEN | Read data, zero when denied or not a counter |
| rd_hit_o | output | 1 | Address selects a counter register |
| rd_denied_o | output | 1 | Counter read refused at this privilege |

## Verification
The bench builds the block with XLEN=32. This makes every upper-half alias meaningful and makes the zero-extension of R11 trivial to predict. The sweep covers all four privilege codes, four mask patterns, all 32 counter indices and both halves. This reaches every permission outcome of R2 to R5 and every data source. Time values with distinct upper and lower words expose any swap of halves. A separate sweep of nearby non-counter addresses exercises the decode edges of R1.

// File: rtl/ctr_read_gate.sv
module ctr_read_gate #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            retire_i,
  input  logic [63:0]     time_i,
  input  logic [1:0]      priv_i,
  input  logic [31:0]     mcen_i,
  input  logic [31:0]     scen_i,
  input  logic [11:0]     csr_addr_i,
  output logic [XLEN-1:0] rd_data_o,
  output logic            rd_hit_o,
  output logic            rd_denied_o
);

  logic [63:0] cyc_q, ret_q, val;
  logic [4:0]  idx;
  logic        upper, allow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_q <= '0;
      ret_q <= '0;
    end else begin
      cyc_q <= cyc_q + 64'd1;
      if (retire_i) ret_q <= ret_q + 64'd1;
    end
  end

  assign idx      = csr_addr_i[4:0];
  assign upper    = csr_addr_i[7];
  assign rd_hit_o = (csr_addr_i[11:8] == 4'hC) && (csr_addr_i[6:5] == 2'b00);

  always_comb begin
    case (priv_i)
      2'b11:   allow = 1'b1;
      2'b01:   allow = mcen_i[idx];
      2'b00:   allow = scen_i[idx];
      default: allow = 1'b0;
    endcase
  end

  always_comb begin
    case (idx)
      5'd1:    val = time_i;
      5'd2:    val = ret_q;
      default: val = cyc_q;
    endcase
  end

  assign rd_denied_o = rd_hit_o & ~allow;
  assign rd_data_o   = !(rd_hit_o && allow) ? '0 :
                       upper ? XLEN'(val[63:32]) : val[XLEN-1:0];

  // R7
  cycle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_q != '1 |=> cyc_q == $past(cyc_q) + 64'd1);
  // R9
  ret_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire_i |=> ret_q == $past(ret_q) + 64'd1);
  // R9
  ret_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !retire_i |=> $stable(ret_q));
  // R2
  mmode_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    priv_i == 2'b11 |-> !rd_denied_o);
  // R6
  denied_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_denied_o |-> rd_data_o == '0);
  // R1
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit_o |-> (!rd_denied_o && rd_data_o == '0));

endmodule

// File: tb/ctr_read_gate_test.sv
module ctr_read_gate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        retire_i = 1'b0;
  logic [63:0] time_i = '0;
  logic [1:0]  priv_i = 2'b11;
  logic [31:0] mcen_i = '0, scen_i = '0;
  logic [11:0] csr_addr_i = 12'hC00;
  logic [31:0] rd_data_o;
  logic        rd_hit_o, rd_denied_o;

  int checks = 0, failures = 0;
  logic [63:0] cyc_m = '0, inst_m = '0;

  ctr_read_gate #(.XLEN(32)) uut (
    .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .time_i(time_i),
    .priv_i(priv_i), .mcen_i(mcen_i), .scen_i(scen_i),
    .csr_addr_i(csr_addr_i), .rd_data_o(rd_data_o),
    .rd_hit_o(rd_hit_o), .rd_denied_o(rd_denied_o));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc_m  <= '0;
      inst_m <= '0;
    end else begin
      cyc_m  <= cyc_m + 64'd1;
      inst_m <= inst_m + (retire_i ? 64'd1 : 64'd0);
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  logic [31:0] pats [4] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h5555_AAAA, 32'h0F0F_3C3C};
  logic [11:0] misses [9] = '{12'hC20, 12'hC3F, 12'hC40, 12'hC7F, 12'hCA0,
                              12'hCFF, 12'hB00, 12'h000, 12'hD05};

  initial begin
    // reset state: R7 and R9 counts read zero in machine mode
    repeat (3) @(negedge clk);
    csr_addr_i = 12'hC00; #2;
    chk("R7 reset cycle", 64'(rd_data_o), 64'd0);
    csr_addr_i = 12'hC02; #2;
    chk("R9 reset instret", 64'(rd_data_o), 64'd0);
    @(negedge clk); rst_n = 1'b1;

    for (int p = 0; p < 4; p++)
      for (int m = 0; m < 4; m++)
        for (int n = 0; n < 32; n++)
          for (int h = 0; h < 2; h++) begin
            logic        allow;
            logic [63:0] sel, v, ev;
            string       ptag, vtag;
            @(negedge clk);
            priv_i     = 2'(p);
            mcen_i     = pats[m];
            scen_i     = {pats[m][15:0], pats[m][31:16]};
            csr_addr_i = 12'hC00 | 12'(h << 7) | 12'(n);
            retire_i   = (n % 3 == 0);
            time_i     = {8'hA5, 8'(p * 16 + m), 16'(n), 16'h1234, 16'(n * 7 + h)};
            #2;
            case (p)
              3: allow = 1'b1;
              1: allow = mcen_i[n];
              0: allow = scen_i[n];
              default: allow = 1'b0;
            endcase
            sel = (n == 1) ? time_i : (n == 2) ? inst_m : cyc_m;
            v   = h ? {32'd0, sel[63:32]} : {32'd0, sel[31:0]};
            ev  = allow ? v : 64'd0;
            ptag = (p == 3) ? "R2 permit" : (p == 1) ? "R3 permit" :
                   (p == 0) ? "R4 permit" : "R5 permit";
            vtag = !allow ? "R6 data" : h ? "R11 data" : (n == 0) ? "R7 data" :
                   (n == 1) ? "R8 data" : (n == 2) ? "R9 data" : "R10 data";
            chk("R1 hit", 64'(rd_hit_o), 64'd1);
            chk(ptag, 64'(rd_denied_o), 64'(!allow));
            chk(vtag, 64'(rd_data_o), ev);
          end

    retire_i = 1'b0;
    for (int p = 0; p < 4; p++)
      for (int a = 0; a < 9; a++) begin
        @(negedge clk);
        priv_i = 2'(p); mcen_i = '0; scen_i = '0;
        csr_addr_i = misses[a];
        #2;
        chk("R1 miss hit", 64'(rd_hit_o), 64'd0);
        chk("R1 miss denied", 64'(rd_denied_o), 64'd0);
        chk("R1 miss data", 64'(rd_data_o), 64'd0);
      end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule